// File: doc/BRIEF.md
# Fully Associative Translation Lookup Buffer

This block holds a set of address translations and searches all of them at once for a presented virtual address and context. Each slot stores a 64-bit tag, with the context number in its low bits and the virtual page above them, and a 64-bit translation word. The translation word carries a valid flag, a page-size code, a used flag and a writable flag. A match needs three things: the slot is valid, the context agrees, and the virtual address agrees above a page boundary. That boundary is set by the slot's page-size code.

The lookup is combinational. It returns a hit flag, the index of the matching slot, that slot's translation word and the access rights the hit grants. A side input tells the block whether the access is a data access or an instruction fetch. When the caller marks the lookup as a real access, a hit sets the slot's used flag on the next clock edge. A replacement policy elsewhere can then read that flag. Slots are loaded through a single synchronous write port that takes an index, a tag and a word. Replacement selection, table walks and miss handling belong to the surrounding logic.

Top module: `tlb_cam`

## Requirements
- R1: After reset every slot is invalid: no lookup hits until a slot has been written.
- R2: A slot can match only while bit 63 of its translation word is 1.
- R3: A slot can match only if the lookup context equals bits 12:0 of the slot's tag.
- R4: The address compare uses bits 63:13, moved up by 3 × the page-size code in word bits 62:61. Code 0 compares bits 63:13, code 1 compares 63:16, code 2 compares 63:19 and code 3 compares 63:22. Lower address bits are ignored.
- R5: When several slots match, the lowest index is reported, together with that slot's word.
- R6: A data hit (`lk_is_fetch` = 0) raises `perm_rd`. It raises `perm_wr` only when word bit 1 is 1, and keeps `perm_ex` low.
- R7: An instruction hit (`lk_is_fetch` = 1) raises `perm_ex` only. `perm_rd` and `perm_wr` stay low.
- R8: A hit while `lk_req` is 1 sets bit 41 (used) of the hit slot's word at the next clock edge. All other bits of the word are unchanged.
- R9: If a write targets the hit slot in the same cycle, the written word is stored exactly, and no used bit is added to it.
- R10: On a miss, `hit`, `hit_idx`, `hit_tte` and all permission outputs are 0.
- R11: A write with `wr_en` = 1 stores `wr_tag` and `wr_tte` at `wr_idx` at the clock edge. The next lookup sees them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_va | input | 64 | Virtual address to look up |
| lk_ctx | input | 13 | Context number to look up |
| lk_is_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| lk_req | input | 1 | Lookup is a real access; a hit marks the slot used |
| hit | output | 1 | A valid slot matched |
| hit_idx | output | 6 | Index of the lowest matching slot |
| hit_tte | output | 64 | Translation word of the reported slot |
| perm_rd | output | 1 | Read allowed |
| perm_wr | output | 1 | Write allowed |
| perm_ex | output | 1 | Execute allowed |
| wr_en | input | 1 | Load a slot |
| wr_idx | input | 6 | Slot index to load |
| wr_tag | input | 64 | Tag to store |
| wr_tte | input | 64 | Translation word to store |

## Verification
The assertions check the following on every cycle:
- Permissions agree with the access kind and the reported word.
- A reported word is always valid.
- A miss leaves every output at zero.
- A qualified hit that no write collides with leaves the slot marked used one cycle later.

Only the bench scenarios can show the remaining behaviour. This covers whether the correct slot is chosen: the page-size code widening the compare, a context mismatch, the lowest-index choice among duplicates, and a colliding write winning over the used update. It also covers reset emptiness and the write port.

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES  = 64,
  parameter int CTX_W    = 13,
  parameter int PG_SHIFT = 13,
  parameter int IDX_W    = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [63:0]      lk_va,
  input  logic [CTX_W-1:0] lk_ctx,
  input  logic             lk_is_fetch,
  input  logic             lk_req,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [63:0]      hit_tte,
  output logic             perm_rd,
  output logic             perm_wr,
  output logic             perm_ex,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [63:0]      wr_tag,
  input  logic [63:0]      wr_tte
);
  localparam int VALID_B = 63;
  localparam int PS_HI   = 62;
  localparam int PS_LO   = 61;
  localparam int USED_B  = 41;
  localparam int WRITE_B = 1;
  localparam logic [63:0] BASE_MASK = {{(64-PG_SHIFT){1'b1}}, {PG_SHIFT{1'b0}}};

  logic [63:0] tag_q [ENTRIES];
  logic [63:0] tte_q [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [ENTRIES-1:0] used_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [1:0]  ps;
    logic [3:0]  shamt;
    logic [63:0] cmp_mask;
    assign ps       = tte_q[i][PS_HI:PS_LO];
    assign shamt    = {1'b0, ps, 1'b0} + {2'b00, ps};
    assign cmp_mask = BASE_MASK << shamt;
    assign match[i] = tte_q[i][VALID_B]
                    && (tag_q[i][CTX_W-1:0] == lk_ctx)
                    && (((lk_va ^ tag_q[i]) & cmp_mask) == 64'd0);
    assign used_vec[i] = tte_q[i][USED_B];
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) hit_idx = IDX_W'(i);
  end

  assign hit     = |match;
  assign hit_tte = hit ? tte_q[hit_idx] : 64'd0;
  assign perm_rd = hit && !lk_is_fetch;
  assign perm_wr = hit && !lk_is_fetch && hit_tte[WRITE_B];
  assign perm_ex = hit && lk_is_fetch;

  logic mark_used;
  assign mark_used = lk_req && hit && !used_vec[hit_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= 64'd0;
        tte_q[i] <= 64'd0;
      end
    end else begin
      if (mark_used) tte_q[hit_idx][USED_B] <= 1'b1;
      if (wr_en) begin
        tag_q[wr_idx] <= wr_tag;
        tte_q[wr_idx] <= wr_tte;
      end
    end
  end
endmodule

// File: rtl/tlb_cam_chk.sv
module tlb_cam_chk #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_req,
  input logic               lk_is_fetch,
  input logic               hit,
  input logic [IDX_W-1:0]   hit_idx,
  input logic [63:0]        hit_tte,
  input logic               perm_rd,
  input logic               perm_wr,
  input logic               perm_ex,
  input logic               wr_en,
  input logic [IDX_W-1:0]   wr_idx,
  input logic [ENTRIES-1:0] used_vec
);
  a_r2_valid_reported: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> hit_tte[63]);

  a_r6_data_perms: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !lk_is_fetch) |-> (perm_rd && !perm_ex && (perm_wr == hit_tte[1])));

  a_r7_fetch_perms: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && lk_is_fetch) |-> (perm_ex && !perm_rd && !perm_wr));

  a_r10_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_idx == '0 && hit_tte == 64'd0 && !perm_rd && !perm_wr && !perm_ex));

  a_r8_used_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && hit && !(wr_en && wr_idx == hit_idx)) |=> used_vec[$past(hit_idx)]);
endmodule

bind tlb_cam tlb_cam_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_tlb_cam.sv
`timescale 1ns/1ps
module sim_tlb_cam;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] lk_va = '0;
  logic [12:0] lk_ctx = '0;
  logic        lk_is_fetch = 1'b0;
  logic        lk_req = 1'b0;
  logic        hit;
  logic [5:0]  hit_idx;
  logic [63:0] hit_tte;
  logic        perm_rd, perm_wr, perm_ex;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [63:0] wr_tag = '0;
  logic [63:0] wr_tte = '0;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tlb_cam u0 (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(bit v, logic [1:0] ps, bit used, bit w);
    logic [63:0] t = 64'h0000_0000_0000_1000;
    t[63] = v; t[62:61] = ps; t[41] = used; t[1] = w;
    return t;
  endfunction

  task automatic wr(logic [5:0] i, logic [63:0] tg, logic [63:0] tt);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_tag = tg; wr_tte = tt;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(logic [63:0] va, logic [12:0] ctx, bit fetch);
    @(negedge clk);
    lk_va = va; lk_ctx = ctx; lk_is_fetch = fetch; lk_req = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    look(64'd0, 13'd0, 1'b0);
    chk("R1 hit after reset", {63'd0, hit}, 64'd0);
    look(64'hFFFF_FFFF_FFFF_E000, 13'h1FFF, 1'b0);
    chk("R1 hit any after reset", {63'd0, hit}, 64'd0);
  endtask

  task automatic t_basic;
    logic [63:0] tg = 64'h0000_1234_5678_0000 | 64'h0AB;
    logic [63:0] tt = mk(1, 2'd0, 0, 1);
    wr(6'd3, tg, tt);
    look(64'h0000_1234_5678_1FFF, 13'h0AB, 1'b0);
    chk("R11 hit after write", {63'd0, hit}, 64'd1);
    chk("R11 index", {58'd0, hit_idx}, 64'd3);
    chk("R11 word", hit_tte, tt);
    chk("R6 data perms rd/wr/ex", {61'd0, perm_rd, perm_wr, perm_ex}, 64'b110);
    look(64'h0000_1234_5678_0000, 13'h0AC, 1'b0);
    chk("R3 context mismatch", {63'd0, hit}, 64'd0);
    chk("R10 miss outputs", {hit_tte[63:8], hit_idx, perm_rd, perm_wr}, 64'd0);
    chk("R10 miss ex", {63'd0, perm_ex}, 64'd0);
    wr(6'd3, tg, mk(0, 2'd0, 0, 1));
    look(64'h0000_1234_5678_0000, 13'h0AB, 1'b0);
    chk("R2 invalid slot ignored", {63'd0, hit}, 64'd0);
  endtask

  task automatic t_mask;
    logic [63:0] b = 64'h00A0_0000_0000_0000;
    wr(6'd7, b | 64'd5, mk(1, 2'd1, 0, 0));
    look(b ^ (64'd1 << 15), 13'd5, 1'b0);
    chk("R4 size1 bit15 ignored", {63'd0, hit}, 64'd1);
    look(b ^ (64'd1 << 16), 13'd5, 1'b0);
    chk("R4 size1 bit16 compared", {63'd0, hit}, 64'd0);
    wr(6'd7, b | 64'd5, mk(1, 2'd3, 0, 0));
    look(b ^ (64'd1 << 21), 13'd5, 1'b0);
    chk("R4 size3 bit21 ignored", {63'd0, hit}, 64'd1);
    look(b ^ (64'd1 << 22), 13'd5, 1'b0);
    chk("R4 size3 bit22 compared", {63'd0, hit}, 64'd0);
    wr(6'd7, b | 64'd5, mk(1, 2'd0, 0, 0));
    look(b ^ (64'd1 << 12), 13'd5, 1'b0);
    chk("R4 size0 bit12 ignored", {63'd0, hit}, 64'd1);
    look(b ^ (64'd1 << 13), 13'd5, 1'b0);
    chk("R4 size0 bit13 compared", {63'd0, hit}, 64'd0);
    chk("R6 no-write slot perm_wr", {63'd0, perm_wr}, 64'd0);
  endtask

  task automatic t_priority;
    logic [63:0] b = 64'h0BCD_0000_0040_0000;
    wr(6'd20, b | 64'h11, mk(1, 2'd0, 0, 1));
    wr(6'd10, b | 64'h11, mk(1, 2'd0, 0, 0));
    look(b, 13'h11, 1'b0);
    chk("R5 lowest index", {58'd0, hit_idx}, 64'd10);
    chk("R5 word of lowest", {63'd0, perm_wr}, 64'd0);
    wr(6'd10, b | 64'h11, mk(0, 2'd0, 0, 0));
    look(b, 13'h11, 1'b0);
    chk("R5 next index", {58'd0, hit_idx}, 64'd20);
    chk("R6 writable perm_wr", {63'd0, perm_wr}, 64'd1);
    look(b, 13'h11, 1'b1);
    chk("R7 fetch perms rd/wr/ex", {61'd0, perm_rd, perm_wr, perm_ex}, 64'b001);
  endtask

  task automatic t_used;
    logic [63:0] b = 64'h0BCD_0000_0040_0000;
    logic [63:0] tt = mk(1, 2'd0, 0, 1);
    look(b, 13'h11, 1'b0);
    chk("R8 used clear before", {63'd0, hit_tte[41]}, 64'd0);
    lk_req = 1'b1;
    @(negedge clk);
    lk_req = 1'b0;
    #1;
    chk("R8 used set after access", hit_tte, tt | (64'd1 << 41));
    wr(6'd20, b | 64'h11, tt);
    look(b, 13'h11, 1'b0);
    lk_req = 1'b1;
    wr_en = 1'b1; wr_idx = 6'd20; wr_tag = b | 64'h11; wr_tte = mk(1, 2'd0, 0, 0);
    @(negedge clk);
    lk_req = 1'b0; wr_en = 1'b0;
    #1;
    chk("R9 write beats used update", hit_tte, mk(1, 2'd0, 0, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_mask();
    t_priority();
    t_used();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule